// File: doc/BRIEF.md
# Presettable Decimal Digit Counter

This block is a four-bit synchronous counter that walks through the decimal codes 0 to 9 on rising clock edges and returns to 0 after 9. A digit can be preset from a four-bit input, cleared through an active-low clear, and stopped by either of two active-high count enables. One enable gates only this digit. The other enable also gates the carry output, so the carry can ripple through a row of digits.

A row of digits forms a synchronous multi-digit decimal counter. Each digit's carry output drives the carry-gated enable of the next, more significant digit. The global run/stop signal drives the other enable on every digit. A build parameter chooses between two kinds of clear. One acts at once, with no clock. The other acts only at the next rising edge.

The six codes above 9 are never reached by counting. They can still appear through a preset or at power-up. From any of them the counter returns to the decimal sequence within two counting edges.

Top module: `bcd_digit_counter`

## Requirements
- R1: With counting enabled, the digit advances by one per rising edge through 0..9, and code 9 is followed by 0.
- R2: Apart from an immediate clear, the digit changes only on a rising clock edge. Changes to the preset value, the load strobe or the enables between edges leave it unchanged.
- R3: Priority at an edge, highest first: clear, load, count, hold. A load requested together with a clear yields 0. A load requested together with both enables yields the preset value.
- R4: With CLEAR_ASYNC=1, a low `clear_n` drives the digit to 0 at once, without waiting for a clock edge, and holds it at 0 while low.
- R5: With CLEAR_ASYNC=0, a low `clear_n` leaves the digit untouched until the next rising edge, which sets it to 0.
- R6: With `clear_n` high and `load_n` low, the next rising edge copies `load_val` into the digit. This includes codes 10..15, which are stored unchanged.
- R7: With `clear_n` and `load_n` high, the digit advances only when both `cnt_en_p` and `cnt_en_t` are 1. If either is 0, the digit holds.
- R8: `carry_out` is 1 exactly when `cnt_en_t` is 1 and the digit is 9. It does not depend on `cnt_en_p` and it follows `cnt_en_t` without a clock.
- R9: Counting from an unused code follows 10→11→6, 12→13→4 and 14→15→2. The digit is therefore back in 0..9 after at most two counting edges.
- R10: Two digits chained carry-to-`cnt_en_t`, sharing `cnt_en_p`, count 00 to 99 and then wrap to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clear_n | input | 1 | Active-low clear. Immediate or edge-timed, depending on CLEAR_ASYNC |
| load_n | input | 1 | Active-low preset strobe |
| load_val | input | 4 | Value copied into the digit on a preset |
| cnt_en_p | input | 1 | Count enable that gates this digit only |
| cnt_en_t | input | 1 | Count enable that also gates the carry output |
| digit | output | 4 | Current counter code |
| carry_out | output | 1 | High at code 9 while `cnt_en_t` is high |

## Verification
The bench chains two digits and runs them through a full 00..99 pass and across the wrap. A design that carried on the wrong enable, or carried at the wrong code, would show up as a high digit that skips or stalls. Every unused code is preset and then counted twice. A wrong recovery map would land on a code other than 6, 4 or 2, or would stay above 9. Clear-versus-load and load-versus-count collisions are driven directly, so a priority swap shows up as a preset value appearing where 0 or a count was due. Both clear styles are sampled between edges. An edge-timed clear that acts early, or an immediate clear that waits for the clock, is caught in the cycle where it happens.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
   localparam int unsigned CODE_W   = 4;
   localparam int unsigned LAST_DEC = 9;

   typedef logic [CODE_W-1:0] code_t;

   typedef enum logic [1:0] {
      OP_CLEAR = 2'd0,
      OP_LOAD  = 2'd1,
      OP_COUNT = 2'd2,
      OP_HOLD  = 2'd3
   } op_t;

   // Successor of a code when counting; unused codes fold back into 0..9.
   function automatic code_t code_advance(input code_t c);
      code_t r;
      if (c < code_t'(LAST_DEC))
         r = c + code_t'(1);
      else if (c == code_t'(LAST_DEC))
         r = '0;
      else if (!c[0])
         r = c + code_t'(1);
      else
         r = code_t'(5'd17 - {1'b0, c});
      return r;
   endfunction
endpackage

// File: rtl/bcd_step_logic.sv
module bcd_step_logic
   import bcd_cnt_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic         clear_n,
   input  logic         load_n,
   input  logic         en_p,
   input  logic         en_t,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] cur,
   output op_t          op,
   output logic [W-1:0] nxt
);
   always_comb begin
      if (!clear_n)
         op = OP_CLEAR;
      else if (!load_n)
         op = OP_LOAD;
      else if (en_p && en_t)
         op = OP_COUNT;
      else
         op = OP_HOLD;
   end

   always_comb begin
      unique case (op)
         OP_CLEAR: nxt = '0;
         OP_LOAD:  nxt = load_val;
         OP_COUNT: nxt = code_advance(cur);
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg #(
   parameter int unsigned W           = 4,
   parameter bit          CLEAR_ASYNC = 1'b1
) (
   input  logic         clk,
   input  logic         clear_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (CLEAR_ASYNC) begin : g_async
         always_ff @(posedge clk or negedge clear_n) begin
            if (!clear_n)
               q <= '0;
            else
               q <= d;
         end
      end else begin : g_sync
         // d is already zero when clear_n is low (clear wins in the step logic)
         always_ff @(posedge clk) begin
            q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/bcd_carry_decode.sv
module bcd_carry_decode #(
   parameter int unsigned W    = 4,
   parameter int unsigned LAST = 9
) (
   input  logic [W-1:0] cur,
   input  logic         en_t,
   output logic         carry
);
   localparam logic [W-1:0] LAST_CODE = W'(LAST);

   assign carry = en_t && (cur == LAST_CODE);
endmodule

// File: rtl/bcd_digit_counter.sv
module bcd_digit_counter
   import bcd_cnt_pkg::*;
#(
   parameter int unsigned DIGIT_W     = 4,
   parameter int unsigned LAST_CODE   = 9,
   parameter bit          CLEAR_ASYNC = 1'b1
) (
   input  logic               clk,
   input  logic               clear_n,
   input  logic               load_n,
   input  logic [DIGIT_W-1:0] load_val,
   input  logic               cnt_en_p,
   input  logic               cnt_en_t,
   output logic [DIGIT_W-1:0] digit,
   output logic               carry_out
);
   localparam int unsigned CODE_SPAN = 1 << DIGIT_W;
   localparam int unsigned UNUSED_N  = CODE_SPAN - LAST_CODE - 1;

   generate
      if (DIGIT_W != CODE_W) begin : g_bad_width
         $error("bcd_digit_counter: DIGIT_W must equal %0d", CODE_W);
      end
      if (LAST_CODE != LAST_DEC || UNUSED_N != 6) begin : g_bad_last
         $error("bcd_digit_counter: LAST_CODE must be %0d", LAST_DEC);
      end
   endgenerate

   op_t                op;
   logic [DIGIT_W-1:0] nxt;

   bcd_step_logic #(.W(DIGIT_W)) u_step (
      .clear_n  (clear_n),
      .load_n   (load_n),
      .en_p     (cnt_en_p),
      .en_t     (cnt_en_t),
      .load_val (load_val),
      .cur      (digit),
      .op       (op),
      .nxt      (nxt)
   );

   bcd_state_reg #(.W(DIGIT_W), .CLEAR_ASYNC(CLEAR_ASYNC)) u_reg (
      .clk     (clk),
      .clear_n (clear_n),
      .d       (nxt),
      .q       (digit)
   );

   bcd_carry_decode #(.W(DIGIT_W), .LAST(LAST_CODE)) u_carry (
      .cur   (digit),
      .en_t  (cnt_en_t),
      .carry (carry_out)
   );
endmodule

// File: rtl/bcd_digit_counter_chk.sv
module bcd_digit_counter_chk #(
   parameter bit CLEAR_ASYNC = 1'b1
) (
   input logic       clk,
   input logic       clear_n,
   input logic       load_n,
   input logic [3:0] load_val,
   input logic       cnt_en_p,
   input logic       cnt_en_t,
   input logic [3:0] digit,
   input logic       carry_out
);
   // Checks start once a clear has put the state in a known value.
   logic armed = 1'b0;
   always_ff @(posedge clk or negedge clear_n) begin
      if (!clear_n) armed <= 1'b1;
   end

   wire run = clear_n && load_n && cnt_en_p && cnt_en_t;

   // R1
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!armed || !clear_n)
      (run && digit == 4'd9) |=> digit == 4'd0);

   // R6
   load_copy_chk: assert property (@(posedge clk) disable iff (!armed || !clear_n)
      (clear_n && !load_n) |=> digit == $past(load_val));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!armed || !clear_n)
      (clear_n && load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(digit));

   // R8
   carry_decode_chk: assert property (@(posedge clk) disable iff (!armed)
      carry_out == (cnt_en_t && digit == 4'd9));

   // R9
   recover_odd_chk: assert property (@(posedge clk) disable iff (!armed || !clear_n)
      (run && digit > 4'd9 && digit[0]) |=> digit <= 4'd9);

   // R9
   recover_even_chk: assert property (@(posedge clk) disable iff (!armed || !clear_n)
      (run && digit > 4'd9 && !digit[0]) |=> digit == $past(digit) + 4'd1);

   generate
      if (CLEAR_ASYNC) begin : g_async_chk
         // R4
         clear_now_chk: assert property (@(posedge clk) disable iff (!armed)
            !clear_n |-> digit == 4'd0);
      end else begin : g_sync_chk
         // R5
         clear_edge_chk: assert property (@(posedge clk) disable iff (!armed)
            !clear_n |=> digit == 4'd0);
      end
   endgenerate
endmodule

bind bcd_digit_counter bcd_digit_counter_chk #(.CLEAR_ASYNC(CLEAR_ASYNC)) u_chk (
   .clk       (clk),
   .clear_n   (clear_n),
   .load_n    (load_n),
   .load_val  (load_val),
   .cnt_en_p  (cnt_en_p),
   .cnt_en_t  (cnt_en_t),
   .digit     (digit),
   .carry_out (carry_out)
);

// File: tb/sim_bcd_digit_counter.sv
`timescale 1ns/1ps
module sim_bcd_digit_counter;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       clear_n = 1'b1, clear_s_n = 1'b1;
   logic       load_lo_n = 1'b1, load_hi_n = 1'b1;
   logic [3:0] val_lo = '0, val_hi = '0;
   logic       ep = 1'b0, et = 1'b0;

   logic [3:0] d_lo, d_hi, d_s;
   logic       c_lo, c_hi, c_s;

   bcd_digit_counter #(.CLEAR_ASYNC(1'b1)) u0 (
      .clk(clk), .clear_n(clear_n), .load_n(load_lo_n), .load_val(val_lo),
      .cnt_en_p(ep), .cnt_en_t(et), .digit(d_lo), .carry_out(c_lo));
   bcd_digit_counter #(.CLEAR_ASYNC(1'b1)) u1 (
      .clk(clk), .clear_n(clear_n), .load_n(load_hi_n), .load_val(val_hi),
      .cnt_en_p(ep), .cnt_en_t(c_lo), .digit(d_hi), .carry_out(c_hi));
   bcd_digit_counter #(.CLEAR_ASYNC(1'b0)) u2 (
      .clk(clk), .clear_n(clear_s_n), .load_n(load_lo_n), .load_val(val_lo),
      .cnt_en_p(ep), .cnt_en_t(et), .digit(d_s), .carry_out(c_s));

   int checks = 0, errors = 0;
   logic [3:0] m_lo = '0, m_hi = '0, m_s = '0;

   function automatic logic [3:0] ref_adv(input logic [3:0] c);
      case (c)
         4'd9:  return 4'd0;
         4'd10: return 4'd11;
         4'd11: return 4'd6;
         4'd12: return 4'd13;
         4'd13: return 4'd4;
         4'd14: return 4'd15;
         4'd15: return 4'd2;
         default: return c + 4'd1;
      endcase
   endfunction

   function automatic logic [3:0] ref_next(input logic [3:0] c, input logic clr_n,
                                           input logic ld_n, input logic [3:0] v,
                                           input logic en);
      if (!clr_n) return 4'd0;
      if (!ld_n) return v;
      if (en) return ref_adv(c);
      return c;
   endfunction

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // One clock: update models from the inputs present now, then compare.
   task automatic tick(input string tag);
      logic [3:0] n_lo, n_hi, n_s;
      n_lo = ref_next(m_lo, clear_n, load_lo_n, val_lo, ep && et);
      n_hi = ref_next(m_hi, clear_n, load_hi_n, val_hi, ep && et && m_lo == 4'd9);
      n_s  = ref_next(m_s, clear_s_n, load_lo_n, val_lo, ep && et);
      @(posedge clk);
      @(negedge clk);
      if (!clear_n) begin n_lo = '0; n_hi = '0; end
      m_lo = n_lo; m_hi = n_hi; m_s = n_s;
      chk(tag, d_lo, m_lo);
      chk(tag, d_hi, m_hi);
      chk(tag, d_s, m_s);
      chk({tag, " R8 carry"}, {3'b0, c_lo}, {3'b0, et && m_lo == 4'd9});
      chk({tag, " R8 carry"}, {3'b0, c_s}, {3'b0, et && m_s == 4'd9});
      chk({tag, " R10 carry"}, {3'b0, c_hi}, {3'b0, et && m_lo == 4'd9 && m_hi == 4'd9});
   endtask

   task automatic finish_run;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      // reset state, both clear styles
      clear_n = 1'b0; clear_s_n = 1'b0;
      tick("R4 R5 reset");
      clear_n = 1'b1; clear_s_n = 1'b1;

      // R10: full two-digit pass and wrap
      ep = 1'b1; et = 1'b1;
      for (int i = 0; i < 100; i++) tick("R10 R1 cascade");
      chk("R10 wrap lo", d_lo, 4'd0);
      chk("R10 wrap hi", d_hi, 4'd0);

      // R7 hold under each enable
      for (int i = 0; i < 3; i++) tick("R7 count");
      ep = 1'b0;
      for (int i = 0; i < 3; i++) tick("R7 hold ep");
      ep = 1'b1; et = 1'b0;
      for (int i = 0; i < 3; i++) tick("R7 hold et");

      // R8: carry follows et without a clock, ignores ep
      load_lo_n = 1'b0; val_lo = 4'd9; tick("R6 load 9");
      load_lo_n = 1'b1;
      #1 chk("R8 et low", {3'b0, c_lo}, 4'd0);
      et = 1'b1; ep = 1'b0;
      #1 chk("R8 et high ep low", {3'b0, c_lo}, 4'd1);
      @(negedge clk);

      // R3: load beats count, clear beats load
      ep = 1'b1; load_lo_n = 1'b0; val_lo = 4'd3;
      tick("R3 load over count");
      clear_s_n = 1'b0; val_lo = 4'd7;
      tick("R3 clear over load");
      clear_s_n = 1'b1; load_lo_n = 1'b1;

      // R2: inputs change between edges, digit stays
      val_lo = 4'd5; load_lo_n = 1'b0; ep = 1'b0;
      #3 chk("R2 no early load", d_lo, m_lo);
      chk("R2 no early load sync", d_s, m_s);
      load_lo_n = 1'b1; ep = 1'b1;
      @(negedge clk);
      m_lo = ref_next(m_lo, 1'b1, 1'b1, 4'd0, 1'b1);
      m_hi = ref_next(m_hi, 1'b1, 1'b1, 4'd0, m_lo == 4'd0);
      m_s  = ref_next(m_s, 1'b1, 1'b1, 4'd0, 1'b1);
      chk("R2 lo", d_lo, m_lo);

      // R9 + R6: every unused code preset then counted twice
      for (int v = 10; v < 16; v++) begin
         load_lo_n = 1'b0; val_lo = 4'(v);
         tick("R6 unused load");
         load_lo_n = 1'b1;
         tick("R9 step one");
         tick("R9 step two");
         checks++;
         if (d_lo > 4'd9) begin
            errors++;
            $display("FAIL R9 actual=%0d expected<=9", d_lo);
         end
      end

      // R5: edge-timed clear waits for the edge; R4: immediate clear
      load_lo_n = 1'b0; val_lo = 4'd6; tick("R6 preset");
      load_lo_n = 1'b1; ep = 1'b0;
      clear_s_n = 1'b0;
      #3 chk("R5 before edge", d_s, 4'd6);
      tick("R5 after edge");
      clear_s_n = 1'b1;
      load_lo_n = 1'b0; tick("R6 preset again");
      load_lo_n = 1'b1;
      #3 clear_n = 1'b0;
      #1 chk("R4 immediate lo", d_lo, 4'd0);
      chk("R4 immediate hi", d_hi, 4'd0);
      @(negedge clk);
      m_lo = '0; m_hi = '0;
      tick("R4 held low");
      clear_n = 1'b1;

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         ep        = ($urandom % 4) != 0;
         et        = ($urandom % 4) != 0;
         load_lo_n = ($urandom % 12) != 0;
         load_hi_n = ($urandom % 16) != 0;
         val_lo    = 4'($urandom);
         val_hi    = 4'($urandom % 10);
         clear_n   = ($urandom % 40) != 0;
         clear_s_n = ($urandom % 40) != 0;
         tick("R3 R7 R9 random");
      end
      clear_n = 1'b1; clear_s_n = 1'b1;
      finish_run();
   end
endmodule